// File: doc/BRIEF.md
# Multi-Width ALU with Condition Flags

This block is the arithmetic-logic unit of an 8/16/32-bit register-based processor. Each cycle that the valid strobe is high, it takes an operation, an operand size, two operands, the current four flags and an 8-bit immediate. It then registers a zero-extended result, a write-enable and a new flag nibble. The same adder and logic path serve all three sizes. Carry, overflow, sign and zero are each taken at the top of the selected width.

The unit also applies AND, OR or XOR of an immediate directly to the flag nibble. A branch evaluator reads the registered flags and tells the sequencer whether the selected condition holds. Instruction decode, the register file and memory access sit outside the block.

Top module: `mw_alu`

## Requirements
- R1: The flag nibble is packed as N in bit 3, Z in bit 2, V in bit 1 and C in bit 0. A synchronous active-high reset clears the flags, the result and the write-enable.
- R2: Size code 0 selects byte, 1 selects word, and 2 or 3 selects long. Operand bits above the selected width are ignored, and the result is zero-extended to 32 bits.
- R3: Op 0 (add) gives a+b and op 1 (add with carry) gives a+b+C. C is the carry out of the top bit of the width. V is set when both operands share a sign and the result sign differs from it.
- R4: Op 2 (subtract) gives a-b and op 3 (subtract with borrow) gives a-b-C. C is set on an unsigned borrow. V is set on signed overflow. Op 4 (compare) sets the flags like op 2 but drives the write-enable low.
- R5: Op 5 (negate) gives 0-a. V is set only when a is the most negative value of the width, and C is set when a is nonzero.
- R6: Op 6 (increment) gives a+1 and op 7 (decrement) gives a-1. V flags signed overflow of the width, and C keeps its input value.
- R7: Op 8 (AND), op 9 (OR), op 10 (XOR) and op 11 (move b) set N from the result top bit and Z from a zero result. They clear V and keep the input C.
- R8: Op 12, op 13 and op 14 replace all four flags with flags_i AND, OR or XOR the low four immediate bits. The write-enable stays low, and the result carries the new flags zero-extended.
- R9: Result, flags and write-enable change on the rising edge after a valid strobe. Without a strobe the result and flags hold and the write-enable is low.
- R10: The branch output follows the registered flags for the condition codes 0 always, 1 never, 2 greater (Z or (N xor V) is 0), 3 less-or-equal (that expression is 1), 4 equal (Z), 5 not-equal, 6 greater-or-equal (N xor V is 0) and 7 less (N xor V is 1).
- R11: Op 15 is reserved. A strobe with it leaves the result and the flags unchanged and keeps the write-enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Operand size select |
| a_i | input | 32 | Destination-side operand |
| b_i | input | 32 | Source-side operand |
| flags_i | input | 4 | Current flags, N Z V C |
| imm_i | input | 8 | Immediate for flag logic ops |
| cond_i | input | 3 | Branch condition select |
| res_o | output | 32 | Registered result |
| wr_o | output | 1 | Result write-enable |
| flags_o | output | 4 | Registered new flags |
| take_o | output | 1 | Branch condition holds |

## Verification
Result, flags and write-enable are due one rising edge after the strobe. The bench drives each operation on a falling edge and samples on the next falling edge, so exactly one register stage lies in between. The write-enable pulse is then checked low one cycle later. The branch output is combinational on the registered flags and is checked in the same sampling window as the flags it reads.

// File: rtl/mwalu_pkg.sv
package mwalu_pkg;
  localparam int DATA_W = 32;
  localparam int FLAG_W = 4;
  localparam int IMM_W  = 8;
  localparam int COND_W = 3;

  typedef enum logic [3:0] {
    OP_ADD, OP_ADDC, OP_SUB, OP_SUBB, OP_CMP, OP_NEG, OP_INC, OP_DEC,
    OP_AND, OP_OR, OP_XOR, OP_MOV, OP_CCAND, OP_CCOR, OP_CCXOR, OP_RSVD
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

  function automatic logic [DATA_W-1:0] width_mask(logic [1:0] sz);
    case (sz)
      2'd0:    return DATA_W'(32'h0000_00FF);
      2'd1:    return DATA_W'(32'h0000_FFFF);
      default: return '1;
    endcase
  endfunction

  function automatic logic top_bit(logic [1:0] sz, logic [DATA_W-1:0] v);
    case (sz)
      2'd0:    return v[7];
      2'd1:    return v[15];
      default: return v[DATA_W-1];
    endcase
  endfunction

  // returns {carry out of the width's top bit, masked sum}
  function automatic logic [DATA_W:0] add_sized(logic [1:0] sz, logic [DATA_W-1:0] x,
                                                 logic [DATA_W-1:0] y, logic cin);
    logic [DATA_W-1:0] m;
    logic [DATA_W:0]   s;
    logic              co;
    m = width_mask(sz);
    s = {1'b0, x & m} + {1'b0, y & m} + {{DATA_W{1'b0}}, cin};
    case (sz)
      2'd0:    co = s[8];
      2'd1:    co = s[16];
      default: co = s[DATA_W];
    endcase
    return {co, s[DATA_W-1:0] & m};
  endfunction
endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import mwalu_pkg::*;
(
  input  alu_op_e           op,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  ccr_t              fin,
  output logic [DATA_W-1:0] res,
  output ccr_t              fout,
  output logic              ovf
);
  logic [DATA_W-1:0] x, y;
  logic              cin, borrow_mode, keep_c;
  logic [DATA_W:0]   sum;

  always_comb begin
    x = a; y = b; cin = 1'b0; borrow_mode = 1'b0; keep_c = 1'b0;
    case (op)
      OP_ADDC: cin = fin.c;
      OP_SUB, OP_CMP: begin y = ~b; cin = 1'b1; borrow_mode = 1'b1; end
      OP_SUBB: begin y = ~b; cin = ~fin.c; borrow_mode = 1'b1; end
      OP_NEG: begin x = '0; y = ~a; cin = 1'b1; borrow_mode = 1'b1; end
      OP_INC: begin y = '0; cin = 1'b1; keep_c = 1'b1; end
      OP_DEC: begin y = '1; keep_c = 1'b1; end
      default: ;
    endcase
    sum    = add_sized(size, x, y, cin);
    res    = sum[DATA_W-1:0];
    ovf    = (top_bit(size, x) == top_bit(size, y)) && (top_bit(size, res) != top_bit(size, x));
    fout.n = top_bit(size, res);
    fout.z = (res == '0);
    fout.v = ovf;
    fout.c = keep_c ? fin.c : (borrow_mode ? ~sum[DATA_W] : sum[DATA_W]);
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import mwalu_pkg::*;
(
  input  alu_op_e           op,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  ccr_t              fin,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] res,
  output ccr_t              fout
);
  logic [DATA_W-1:0] m, raw;
  ccr_t              ccr_new;
  logic              is_ccr_op;

  always_comb begin
    m         = width_mask(size);
    raw       = '0;
    ccr_new   = fin;
    is_ccr_op = 1'b0;
    case (op)
      OP_AND:   raw = a & b;
      OP_OR:    raw = a | b;
      OP_XOR:   raw = a ^ b;
      OP_MOV:   raw = b;
      OP_CCAND: begin ccr_new = fin & imm[FLAG_W-1:0]; is_ccr_op = 1'b1; end
      OP_CCOR:  begin ccr_new = fin | imm[FLAG_W-1:0]; is_ccr_op = 1'b1; end
      OP_CCXOR: begin ccr_new = fin ^ imm[FLAG_W-1:0]; is_ccr_op = 1'b1; end
      default: ;
    endcase
    if (is_ccr_op) begin
      res  = {{(DATA_W-FLAG_W){1'b0}}, ccr_new};
      fout = ccr_new;
    end else begin
      res    = raw & m;
      fout.n = top_bit(size, res);
      fout.z = (res == '0);
      fout.v = 1'b0;
      fout.c = fin.c;
    end
  end
endmodule

// File: rtl/alu_branch.sv
module alu_branch
  import mwalu_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  ccr_t              f,
  output logic              take
);
  logic lt_s, le_s;
  assign lt_s = f.n ^ f.v;
  assign le_s = f.z | lt_s;

  always_comb begin
    case (cond)
      3'd0:    take = 1'b1;
      3'd1:    take = 1'b0;
      3'd2:    take = ~le_s;
      3'd3:    take = le_s;
      3'd4:    take = f.z;
      3'd5:    take = ~f.z;
      3'd6:    take = ~lt_s;
      default: take = lt_s;
    endcase
  end
endmodule

// File: rtl/mw_alu.sv
module mw_alu
  import mwalu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [COND_W-1:0] cond_i,
  output logic [DATA_W-1:0] res_o,
  output logic              wr_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              take_o
);
  alu_op_e           op;
  ccr_t              fin;
  logic [DATA_W-1:0] arith_res, logic_res, sel_res;
  ccr_t              arith_fl, logic_fl, sel_fl;
  logic              arith_ovf;
  logic              is_arith, is_rsvd, writes, load;
  logic [DATA_W-1:0] sz_mask;
  logic              neg_at_min;

  assign op  = alu_op_e'(op_i);
  assign fin = ccr_t'(flags_i);

  alu_arith u_arith (.op(op), .size(size_i), .a(a_i), .b(b_i), .fin(fin),
                     .res(arith_res), .fout(arith_fl), .ovf(arith_ovf));

  alu_logic u_logic (.op(op), .size(size_i), .a(a_i), .b(b_i), .fin(fin),
                     .imm(imm_i), .res(logic_res), .fout(logic_fl));

  assign is_arith = (op_i <= 4'd7);
  assign is_rsvd  = (op == OP_RSVD);
  assign writes   = !(op inside {OP_CMP, OP_CCAND, OP_CCOR, OP_CCXOR, OP_RSVD});
  assign load     = valid_i && !is_rsvd;
  assign sel_res  = is_arith ? arith_res : logic_res;
  assign sel_fl   = is_arith ? arith_fl  : logic_fl;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      flags_o <= '0;
      wr_o    <= 1'b0;
    end else begin
      wr_o <= load && writes;
      if (load) begin
        res_o   <= sel_res;
        flags_o <= sel_fl;
      end
    end
  end

  alu_branch u_branch (.cond(cond_i), .f(ccr_t'(flags_o)), .take(take_o));

  // named events for the checks
  assign sz_mask    = width_mask(size_i);
  assign neg_at_min = ((a_i & sz_mask) == (sz_mask ^ (sz_mask >> 1)));

  assert_cmp_nowrite_R4: assert property (@(posedge clk) disable iff (rst)
    valid_i && op == OP_CMP |=> !wr_o);

  assert_incdec_keep_c_R6: assert property (@(posedge clk) disable iff (rst)
    valid_i && (op == OP_INC || op == OP_DEC) |=> flags_o[0] == $past(flags_i[0]));

  assert_logic_flags_R7: assert property (@(posedge clk) disable iff (rst)
    valid_i && (op inside {OP_AND, OP_OR, OP_XOR, OP_MOV})
    |=> !flags_o[1] && flags_o[0] == $past(flags_i[0]) && flags_o[2] == (res_o == '0));

  assert_neg_min_ovf_R5: assert property (@(posedge clk) disable iff (rst)
    valid_i && op == OP_NEG && neg_at_min |=> flags_o[1]);

  assert_byte_zero_ext_R2: assert property (@(posedge clk) disable iff (rst)
    valid_i && !is_rsvd && size_i == 2'd0 |=> res_o[DATA_W-1:8] == '0);

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(flags_o) && $stable(res_o) && !wr_o);

  assert_reserved_noop_R11: assert property (@(posedge clk) disable iff (rst)
    valid_i && is_rsvd |=> $stable(flags_o) && $stable(res_o) && !wr_o);

  assert_ccr_nowrite_R8: assert property (@(posedge clk) disable iff (rst)
    valid_i && (op inside {OP_CCAND, OP_CCOR, OP_CCXOR})
    |=> !wr_o && res_o == {{(DATA_W-FLAG_W){1'b0}}, flags_o});
endmodule

// File: tb/sim_mw_alu.sv
module sim_mw_alu;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NVEC       = 21;

  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i;
  logic [3:0]  op_i;
  logic [1:0]  size_i;
  logic [31:0] a_i, b_i;
  logic [3:0]  flags_i;
  logic [7:0]  imm_i;
  logic [2:0]  cond_i;
  logic [31:0] res_o;
  logic        wr_o;
  logic [3:0]  flags_o;
  logic        take_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  mw_alu u0 (.clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .size_i(size_i),
             .a_i(a_i), .b_i(b_i), .flags_i(flags_i), .imm_i(imm_i), .cond_i(cond_i),
             .res_o(res_o), .wr_o(wr_o), .flags_o(flags_o), .take_o(take_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  // op, size, a, b, flags in, imm, expected result, expected write, expected flags
  localparam logic [118:0] VEC [NVEC] = '{
    {4'd0, 2'd0, 32'h0000_007F, 32'h0000_0001, 4'h0, 8'h00, 32'h0000_0080, 1'b1, 4'hA}, // R3
    {4'd0, 2'd0, 32'h0000_00FF, 32'h0000_0001, 4'h0, 8'h00, 32'h0000_0000, 1'b1, 4'h5}, // R3
    {4'd0, 2'd1, 32'h1234_FFFF, 32'h0000_0001, 4'h0, 8'h00, 32'h0000_0000, 1'b1, 4'h5}, // R2
    {4'd0, 2'd2, 32'h8000_0000, 32'h8000_0000, 4'h0, 8'h00, 32'h0000_0000, 1'b1, 4'h7}, // R3
    {4'd1, 2'd0, 32'h0000_0010, 32'h0000_0020, 4'h1, 8'h00, 32'h0000_0031, 1'b1, 4'h0}, // R3
    {4'd2, 2'd0, 32'h0000_0000, 32'h0000_0001, 4'h0, 8'h00, 32'h0000_00FF, 1'b1, 4'h9}, // R4
    {4'd2, 2'd1, 32'h0000_8000, 32'h0000_0001, 4'h0, 8'h00, 32'h0000_7FFF, 1'b1, 4'h2}, // R4
    {4'd3, 2'd2, 32'h0000_0005, 32'h0000_0003, 4'h1, 8'h00, 32'h0000_0001, 1'b1, 4'h0}, // R4
    {4'd4, 2'd0, 32'h0000_0042, 32'h0000_0042, 4'h0, 8'h00, 32'h0000_0000, 1'b0, 4'h4}, // R4
    {4'd5, 2'd0, 32'h0000_0080, 32'h0000_0000, 4'h0, 8'h00, 32'h0000_0080, 1'b1, 4'hB}, // R5
    {4'd5, 2'd1, 32'h0000_0000, 32'h0000_0000, 4'h0, 8'h00, 32'h0000_0000, 1'b1, 4'h4}, // R5
    {4'd6, 2'd0, 32'h0000_007F, 32'h0000_0000, 4'h1, 8'h00, 32'h0000_0080, 1'b1, 4'hB}, // R6
    {4'd7, 2'd1, 32'h0000_0000, 32'h0000_0000, 4'h0, 8'h00, 32'h0000_FFFF, 1'b1, 4'h8}, // R6
    {4'd7, 2'd3, 32'h8000_0000, 32'h0000_0000, 4'h0, 8'h00, 32'h7FFF_FFFF, 1'b1, 4'h2}, // R6
    {4'd8, 2'd0, 32'h0000_00F0, 32'h0000_000F, 4'h3, 8'h00, 32'h0000_0000, 1'b1, 4'h5}, // R7
    {4'd9, 2'd1, 32'h0000_8000, 32'h0000_0001, 4'h0, 8'h00, 32'h0000_8001, 1'b1, 4'h8}, // R7
    {4'd10,2'd2, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 4'h1, 8'h00, 32'hF0F0_F0F0, 1'b1, 4'h9}, // R7
    {4'd11,2'd0, 32'h0000_0000, 32'h0000_0123, 4'hA, 8'h00, 32'h0000_0023, 1'b1, 4'h0}, // R7
    {4'd12,2'd0, 32'h0000_0000, 32'h0000_0000, 4'hF, 8'hF5, 32'h0000_0005, 1'b0, 4'h5}, // R8
    {4'd13,2'd0, 32'h0000_0000, 32'h0000_0000, 4'h1, 8'h08, 32'h0000_0009, 1'b0, 4'h9}, // R8
    {4'd14,2'd0, 32'h0000_0000, 32'h0000_0000, 4'h6, 8'hFF, 32'h0000_0009, 1'b0, 4'h9}  // R8
  };

  function automatic string tag_of(logic [3:0] op);
    if (op <= 4'd1)  return "R3";
    if (op <= 4'd4)  return "R4";
    if (op == 4'd5)  return "R5";
    if (op <= 4'd7)  return "R6";
    if (op <= 4'd11) return "R7";
    return "R8";
  endfunction

  function automatic logic want_take(logic [2:0] c, logic [3:0] f);
    logic n, z, v, lessv;
    n = f[3]; z = f[2]; v = f[1];
    lessv = (n != v);
    case (c)
      3'd0: return 1'b1;
      3'd1: return 1'b0;
      3'd2: return !(z || lessv);
      3'd3: return z || lessv;
      3'd4: return z;
      3'd5: return !z;
      3'd6: return !lessv;
      default: return lessv;
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(logic [3:0] op, logic [1:0] sz, logic [31:0] a, logic [31:0] b,
                       logic [3:0] f, logic [7:0] imm);
    @(negedge clk);
    valid_i = 1'b1; op_i = op; size_i = sz; a_i = a; b_i = b; flags_i = f; imm_i = imm;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        total++; bad++;
        $display("FAIL R9 watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rst = 1'b1; valid_i = 1'b0; op_i = '0; size_i = '0; a_i = '0; b_i = '0;
    flags_i = '0; imm_i = '0; cond_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "reset flags", 32'(flags_o), 32'h0);
    check("R1", "reset result", res_o, 32'h0);
    check("R1", "reset write", 32'(wr_o), 32'h0);
    rst = 1'b0;

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [118:0] v;
      v = VEC[i];
      issue(v[118:115], v[114:113], v[112:81], v[80:49], v[48:45], v[44:37]);
      check(tag_of(v[118:115]), "result", res_o, v[36:5]);
      check(tag_of(v[118:115]), "write", 32'(wr_o), 32'(v[4]));
      check(tag_of(v[118:115]), "flags", 32'(flags_o), 32'(v[3:0]));
      cond_i = 3'd2; #1;
      check("R10", "greater", 32'(take_o), 32'(want_take(3'd2, v[3:0])));
      cond_i = 3'd3; #1;
      check("R10", "less-or-equal", 32'(take_o), 32'(want_take(3'd3, v[3:0])));
      @(negedge clk);
      check("R9", "write pulse ends", 32'(wr_o), 32'h0);
    end

    // R2: byte result zero-extended, high operand bits ignored
    issue(4'd11, 2'd0, 32'h0, 32'hABCD_EF80, 4'h0, 8'h00);
    check("R2", "byte move", res_o, 32'h0000_0080);
    check("R2", "byte move flags", 32'(flags_o), 32'h8);

    // R9: idle cycles hold result and flags
    valid_i = 1'b0; op_i = 4'd0; a_i = 32'h1; b_i = 32'h1; flags_i = 4'hF;
    repeat (2) @(negedge clk);
    check("R9", "idle result", res_o, 32'h0000_0080);
    check("R9", "idle flags", 32'(flags_o), 32'h8);
    check("R9", "idle write", 32'(wr_o), 32'h0);

    // R11: reserved op does nothing
    issue(4'd15, 2'd2, 32'h1234_5678, 32'h1, 4'h7, 8'hFF);
    check("R11", "reserved result", res_o, 32'h0000_0080);
    check("R11", "reserved flags", 32'(flags_o), 32'h8);
    check("R11", "reserved write", 32'(wr_o), 32'h0);

    // R10: every condition over every flag value, loaded through flag XOR
    for (int f = 0; f < 16; f++) begin
      issue(4'd14, 2'd0, 32'h0, 32'h0, 4'h0, 8'(f));
      for (int c = 0; c < 8; c++) begin
        cond_i = 3'(c); #1;
        check("R10", "condition table", 32'(take_o), 32'(want_take(3'(c), 4'(f))));
      end
    end

    // R1: reset again clears a nonzero state
    issue(4'd13, 2'd0, 32'h0, 32'h0, 4'h0, 8'h0F);
    rst = 1'b1;
    @(negedge clk);
    check("R1", "re-reset flags", 32'(flags_o), 32'h0);
    check("R1", "re-reset result", res_o, 32'h0);
    rst = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule